// File: doc/BRIEF.md
# BCD 24-Hour Time-of-Day Counter with Push-Button Setting

The block keeps the time of day as six BCD digits: hours from 00 to 23, then minutes and seconds from 00 to 59. Each pulse on the one-second enable moves the seconds forward. A seconds rollover moves the minutes forward, and a minute rollover caused by that seconds rollover moves the hours forward. Everything runs in one synchronous clock domain. The second tick and the slow key-scan strobe are single-cycle clock enables made by logic outside the block.

Three active-low push buttons are used to set the time: one for minute advance, one for hour advance and one for seconds clear. Each button is sampled only on scan strobes and passes through its own three-state debouncer. The debounced buttons are then priority-encoded into a single request. While a minute-set or hour-set request is held, its unit goes up by one on every scan strobe, so a held key repeats at the scan rate. These set increments never carry into the next unit up. The clear request holds the seconds at 00 for as long as it lasts.

The block has two single-cycle outputs, one for minute rollover and one for hour rollover. Other logic can use them to count days or to time an hourly chime. All ports are plain level or enable signals. No part of the interface carries a stream, so there is no handshake and no back-pressure.

Top module: `bcd_clock_top`

## Requirements
- R1: On each cycle with `tick_en` high and no clear request, the seconds advance by one in BCD (tens 0..5, ones 0..9), and 59 wraps to 00.
- R2: The minutes are BCD 00..59. They advance by one on the cycle the seconds wrap from 59 to 00, and 59 wraps to 00.
- R3: The hours are BCD 00..23, with 23 wrapping to 00. The hours advance when the minutes wrap because of a seconds wrap.
- R4: A key's debouncer reports it pressed only after the key reads low at two consecutive scan strobes. It stays pressed while later strobes read low. A single high reading at a strobe returns it to idle.
- R5: Debounced keys are priority-encoded with minute-set first, then hour-set, then seconds-clear. At most one request is active in any cycle.
- R6: While the minute-set request is active, each cycle with `scan_en` high adds one to the minutes. A wrap caused this way leaves the hours unchanged, and the seconds are not affected.
- R7: While the hour-set request is active, each cycle with `scan_en` high adds one to the hours. The minutes and seconds are unchanged.
- R8: While the seconds-clear request is active, both seconds digits read 0 from the next cycle on, even when `tick_en` is high. The minutes do not advance.
- R9: `min_carry` is high for exactly the one cycle after the clock edge at which the minutes go from 59 to 00, whatever the cause. During that cycle the minutes read 00.
- R10: `hr_carry` is high for exactly the one cycle after the clock edge at which the hours go from 23 to 00. During that cycle the hours read 00.
- R11: A synchronous active-high `rst` sets the time to 00:00:00, clears both carry outputs and returns every debouncer to idle.
- R12: If a minute-set increment and a seconds wrap occur in the same cycle, the minutes advance by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable, once per second |
| scan_en | input | 1 | One-cycle key-scan enable (about 16 Hz) |
| key_min_n | input | 1 | Minute-advance button, active low |
| key_hr_n | input | 1 | Hour-advance button, active low |
| key_sclr_n | input | 1 | Seconds-clear button, active low |
| hr_tens | output | 4 | Hours tens digit, BCD |
| hr_ones | output | 4 | Hours ones digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| min_ones | output | 4 | Minutes ones digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| sec_ones | output | 4 | Seconds ones digit, BCD |
| min_carry | output | 1 | One-cycle minute rollover pulse |
| hr_carry | output | 1 | One-cycle hour rollover pulse |

## Verification
The effect of a tick, set increment or clear is visible on the digits in the cycle after the edge that samples it, and the rollover pulses appear in that same cycle. A key press adds its first increment only at the third low strobe, because two strobes are spent on debouncing. The key is counted as held going into that third strobe, so releasing it at that strobe still yields one increment. The bench drives inputs just after a falling edge. It steps a cycle-level model of the requirements with those inputs, waits for the next falling edge and compares every output with the model. Every check therefore looks at exactly the cycle in which the result is due.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;
  localparam int DIGIT_W = 4;
  localparam int NKEYS   = 3;
  localparam int KEY_MIN = 0;
  localparam int KEY_HR  = 1;
  localparam int KEY_CLR = 2;

  typedef enum logic [1:0] {
    DB_IDLE = 2'd0,
    DB_ONE  = 2'd1,
    DB_HELD = 2'd2
  } db_state_e;

  typedef enum logic [1:0] {
    RQ_NONE = 2'd0,
    RQ_MIN  = 2'd1,
    RQ_HR   = 2'd2,
    RQ_CLR  = 2'd3
  } req_e;
endpackage

// File: rtl/key_debounce.sv
module key_debounce
  import bcd_clock_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic scan_en,
  input  logic key_n,
  output logic held
);
  db_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (scan_en) begin
      if (key_n) begin
        state_d = DB_IDLE;
      end else begin
        unique case (state_q)
          DB_IDLE: state_d = DB_ONE;
          DB_ONE:  state_d = DB_HELD;
          default: state_d = DB_HELD;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= DB_IDLE;
    else     state_q <= state_d;
  end

  assign held = (state_q == DB_HELD);
endmodule

// File: rtl/key_arbiter.sv
module key_arbiter
  import bcd_clock_pkg::*;
(
  input  logic [NKEYS-1:0] held,
  output req_e             req
);
  always_comb begin
    if (held[KEY_MIN])      req = RQ_MIN;
    else if (held[KEY_HR])  req = RQ_HR;
    else if (held[KEY_CLR]) req = RQ_CLR;
    else                    req = RQ_NONE;
  end
endmodule

// File: rtl/bcd_pair_counter.sv
module bcd_pair_counter
  import bcd_clock_pkg::*;
#(
  parameter int TENS_LAST = 5,
  parameter int ONES_LAST = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               adv,
  output logic [DIGIT_W-1:0] tens,
  output logic [DIGIT_W-1:0] ones,
  output logic               at_last
);
  localparam logic [DIGIT_W-1:0] T_LAST = DIGIT_W'(TENS_LAST);
  localparam logic [DIGIT_W-1:0] O_LAST = DIGIT_W'(ONES_LAST);
  localparam logic [DIGIT_W-1:0] O_MAX  = DIGIT_W'(9);

  assign at_last = (tens == T_LAST) && (ones == O_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tens <= '0;
      ones <= '0;
    end else if (adv) begin
      if (at_last) begin
        tens <= '0;
        ones <= '0;
      end else if (ones == O_MAX) begin
        ones <= '0;
        tens <= tens + 1'b1;
      end else begin
        ones <= ones + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcd_clock_top.sv
module bcd_clock_top
  import bcd_clock_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               scan_en,
  input  logic               key_min_n,
  input  logic               key_hr_n,
  input  logic               key_sclr_n,
  output logic [DIGIT_W-1:0] hr_tens,
  output logic [DIGIT_W-1:0] hr_ones,
  output logic [DIGIT_W-1:0] min_tens,
  output logic [DIGIT_W-1:0] min_ones,
  output logic [DIGIT_W-1:0] sec_tens,
  output logic [DIGIT_W-1:0] sec_ones,
  output logic               min_carry,
  output logic               hr_carry
);
  logic [NKEYS-1:0] keys_n;
  logic [NKEYS-1:0] held;
  req_e             req;
  logic req_min, req_hr, req_clr;
  logic sec_last, min_last, hr_last;
  logic sec_adv, sec_wrap, min_set, min_adv, min_wrap;
  logic hr_set, hr_adv, hr_wrap;

  always_comb begin
    keys_n          = '1;
    keys_n[KEY_MIN] = key_min_n;
    keys_n[KEY_HR]  = key_hr_n;
    keys_n[KEY_CLR] = key_sclr_n;
  end

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    key_debounce u_db (
      .clk     (clk),
      .rst     (rst),
      .scan_en (scan_en),
      .key_n   (keys_n[k]),
      .held    (held[k])
    );
  end

  key_arbiter u_arb (
    .held (held),
    .req  (req)
  );

  assign req_min = (req == RQ_MIN);
  assign req_hr  = (req == RQ_HR);
  assign req_clr = (req == RQ_CLR);

  assign sec_adv  = tick_en & ~req_clr;
  assign sec_wrap = sec_adv & sec_last;
  assign min_set  = req_min & scan_en;
  assign min_adv  = sec_wrap | min_set;
  assign min_wrap = min_adv & min_last;
  assign hr_set   = req_hr & scan_en;
  assign hr_adv   = (min_wrap & sec_wrap) | hr_set;
  assign hr_wrap  = hr_adv & hr_last;

  bcd_pair_counter #(.TENS_LAST(5), .ONES_LAST(9)) u_sec (
    .clk (clk), .rst (rst), .clr (req_clr), .adv (sec_adv),
    .tens (sec_tens), .ones (sec_ones), .at_last (sec_last)
  );

  bcd_pair_counter #(.TENS_LAST(5), .ONES_LAST(9)) u_min (
    .clk (clk), .rst (rst), .clr (1'b0), .adv (min_adv),
    .tens (min_tens), .ones (min_ones), .at_last (min_last)
  );

  bcd_pair_counter #(.TENS_LAST(2), .ONES_LAST(3)) u_hr (
    .clk (clk), .rst (rst), .clr (1'b0), .adv (hr_adv),
    .tens (hr_tens), .ones (hr_ones), .at_last (hr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      min_carry <= 1'b0;
      hr_carry  <= 1'b0;
    end else begin
      min_carry <= min_wrap;
      hr_carry  <= hr_wrap;
    end
  end
endmodule

// File: rtl/bcd_clock_checker.sv
module bcd_clock_checker
  import bcd_clock_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [DIGIT_W-1:0] hr_tens,
  input logic [DIGIT_W-1:0] hr_ones,
  input logic [DIGIT_W-1:0] min_tens,
  input logic [DIGIT_W-1:0] min_ones,
  input logic [DIGIT_W-1:0] sec_tens,
  input logic [DIGIT_W-1:0] sec_ones,
  input logic               min_carry,
  input logic               hr_carry,
  input logic               req_min,
  input logic               req_hr,
  input logic               req_clr
);
  assert_sec_range_R1: assert property (@(posedge clk) disable iff (rst)
    sec_tens <= 4'd5 && sec_ones <= 4'd9);

  assert_min_range_R2: assert property (@(posedge clk) disable iff (rst)
    min_tens <= 4'd5 && min_ones <= 4'd9);

  assert_hr_range_R3: assert property (@(posedge clk) disable iff (rst)
    hr_tens <= 4'd2 && hr_ones <= 4'd9 && !(hr_tens == 4'd2 && hr_ones > 4'd3));

  assert_one_request_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_min, req_hr, req_clr}));

  assert_clear_holds_R8: assert property (@(posedge clk) disable iff (rst)
    req_clr |=> (sec_tens == 4'd0 && sec_ones == 4'd0));

  assert_min_carry_zero_R9: assert property (@(posedge clk) disable iff (rst)
    min_carry |-> (min_tens == 4'd0 && min_ones == 4'd0));

  assert_min_carry_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    min_carry |=> !min_carry);

  assert_hr_carry_zero_R10: assert property (@(posedge clk) disable iff (rst)
    hr_carry |-> (hr_tens == 4'd0 && hr_ones == 4'd0));

  assert_hr_carry_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    hr_carry |=> !hr_carry);

  assert_reset_zero_R11: assert property (@(posedge clk)
    rst |=> ({hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones} == '0
             && !min_carry && !hr_carry));
endmodule

bind bcd_clock_top bcd_clock_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .hr_tens   (hr_tens),
  .hr_ones   (hr_ones),
  .min_tens  (min_tens),
  .min_ones  (min_ones),
  .sec_tens  (sec_tens),
  .sec_ones  (sec_ones),
  .min_carry (min_carry),
  .hr_carry  (hr_carry),
  .req_min   (req_min),
  .req_hr    (req_hr),
  .req_clr   (req_clr)
);

// File: tb/bcd_clock_top_tb_top.sv
`timescale 1ns/1ps
module bcd_clock_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0, scan_en = 1'b0;
  logic key_min_n = 1'b1, key_hr_n = 1'b1, key_sclr_n = 1'b1;
  logic [3:0] hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones;
  logic min_carry, hr_carry;

  always #4 clk = ~clk;

  bcd_clock_top dut_i (
    .clk (clk), .rst (rst), .tick_en (tick_en), .scan_en (scan_en),
    .key_min_n (key_min_n), .key_hr_n (key_hr_n), .key_sclr_n (key_sclr_n),
    .hr_tens (hr_tens), .hr_ones (hr_ones), .min_tens (min_tens),
    .min_ones (min_ones), .sec_tens (sec_tens), .sec_ones (sec_ones),
    .min_carry (min_carry), .hr_carry (hr_carry)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  int m_h = 0, m_m = 0, m_s = 0;
  bit e_mc = 0, e_hc = 0;
  int deb [3] = '{0, 0, 0};

  function automatic logic [7:0] bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle model of the requirements, advanced with the inputs applied this cycle.
  task automatic model_next(input bit t, sc, pm, ph, pc, r);
    bit rq_min, rq_hr, rq_clr, scw, madv, mw, hadv;
    bit pr [3];
    if (r) begin
      m_h = 0; m_m = 0; m_s = 0; e_mc = 0; e_hc = 0;
      foreach (deb[i]) deb[i] = 0;
      return;
    end
    rq_min = (deb[0] == 2);
    rq_hr  = !rq_min && (deb[1] == 2);
    rq_clr = !rq_min && !rq_hr && (deb[2] == 2);
    scw = 0;
    if (rq_clr) m_s = 0;
    else if (t) begin
      if (m_s == 59) begin m_s = 0; scw = 1; end
      else m_s++;
    end
    madv = scw || (rq_min && sc);
    mw = madv && (m_m == 59);
    if (madv) m_m = (m_m + 1) % 60;
    hadv = (mw && scw) || (rq_hr && sc);
    e_hc = hadv && (m_h == 23);
    if (hadv) m_h = (m_h + 1) % 24;
    e_mc = mw;
    pr[0] = pm; pr[1] = ph; pr[2] = pc;
    if (sc) foreach (deb[i]) deb[i] = pr[i] ? ((deb[i] == 0) ? 1 : 2) : 0;
  endtask

  task automatic step(input bit t, sc, pm, ph, pc, r);
    tick_en = t; scan_en = sc; rst = r;
    key_min_n = !pm; key_hr_n = !ph; key_sclr_n = !pc;
    model_next(t, sc, pm, ph, pc, r);
    @(negedge clk);
    check({8'h0, hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones},
          {8'h0, bcd(m_h), bcd(m_m), bcd(m_s)}, "R1 R2 R3 R6 R7 R8 time");
    check({30'h0, min_carry, hr_carry}, {30'h0, e_mc, e_hc}, "R9 R10 carry");
  endtask

  task automatic expect_time(input int h, m, s, input string req);
    check({8'h0, hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones},
          {8'h0, bcd(h), bcd(m), bcd(s)}, req);
  endtask

  // one debounced minute increment: two low strobes, then release at the third
  task automatic min_once();
    step(0, 1, 1, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(0, 0, 0, 0, 0, 1);
    expect_time(0, 0, 0, "R11 reset time");
    check({31'h0, min_carry | hr_carry}, 32'h0, "R11 reset carries");

    // R4: two low strobes give no increment yet, the third does
    step(0, 1, 1, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0);
    expect_time(0, 0, 0, "R4 not yet held");
    step(0, 1, 1, 0, 0, 0);
    expect_time(0, 1, 0, "R6 first increment");
    step(0, 1, 0, 0, 0, 0);
    expect_time(0, 2, 0, "R6 held going into release strobe");
    // R4: glitch low-high-low never reaches held
    step(0, 1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    expect_time(0, 2, 0, "R4 glitch ignored");

    // R5: minute and hour keys both held: minutes win
    step(0, 1, 1, 1, 0, 0);
    step(0, 1, 1, 1, 0, 0);
    step(0, 1, 1, 1, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    expect_time(0, 4, 0, "R5 minute priority");

    // R7: hours to 23, minutes untouched
    while (m_h != 22) step(0, 1, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    expect_time(23, 4, 0, "R7 hour set");

    // R6: minutes to 59 then one more wraps with no hour carry
    while (m_m != 58) step(0, 1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    expect_time(23, 59, 0, "R6 minutes 59");
    min_once();
    expect_time(23, 0, 0, "R6 set wrap keeps hours");
    check({31'h0, min_carry}, 32'h1, "R9 set wrap pulse");
    step(0, 0, 0, 0, 0, 0);
    check({31'h0, min_carry}, 32'h0, "R9 single cycle");
    while (m_m != 58) step(0, 1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);

    // R1 R2 R3 R10: full rollover from 23:59:59
    while (m_s != 59) step(1, 0, 0, 0, 0, 0);
    expect_time(23, 59, 59, "R1 seconds 59");
    step(1, 0, 0, 0, 0, 0);
    expect_time(0, 0, 0, "R3 day wrap");
    check({30'h0, min_carry, hr_carry}, 32'h3, "R10 both pulses");

    // R8: clear holds seconds while tick keeps running
    while (m_s != 5) step(1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 1, 0);
    step(1, 1, 0, 0, 1, 0);
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 1, 0);
    expect_time(0, 0, 0, "R8 seconds held at zero");
    step(1, 1, 0, 0, 0, 0);

    // R12: minute-set increment coincides with a seconds wrap
    while (m_s != 59) step(1, 0, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    expect_time(0, 1, 0, "R12 single advance");

    // constrained random with a fixed seed
    begin
      bit pm = 0, ph = 0, pc = 0;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 150000; i++) begin
        if ($urandom_range(0, 199) == 0) pm = !pm;
        if ($urandom_range(0, 199) == 0) ph = !ph;
        if ($urandom_range(0, 399) == 0) pc = !pc;
        step($urandom_range(0, 1) == 1, $urandom_range(0, 7) == 0, pm, ph, pc,
             $urandom_range(0, 29999) == 0);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule